// File: doc/BRIEF.md
# JTAG Startup Sequencer with Instruction-Register Length Detection

This block is a JTAG master that brings an unknown scan chain into a known state and measures the combined instruction-register length of every device on it. One start pulse launches a fixed run of 283 TCK cycles. The run resets the TAP controllers, walks them into Shift-IR, and shifts a 32-bit marker word onto TDI, least significant bit first. Next it shifts 240 ones, which place every device in bypass, and it finishes in Update-IR.

While the run is in Shift-IR, the block samples TDO on each rising TCK edge and looks for the marker word in the returned stream. The number of TCK cycles by which the marker comes back late is the total instruction-register length of the chain. A system-clock divider sets the TCK rate. The result stays on `found` and `irLength` until the next run begins, and `done` marks the end of the run.

Top module: `jtag_ir_probe`

## Requirements
- R1: After reset, tck=0, tms=1, tdi=0, done=0, found=0 and irLength=0.
- R2: Each TCK half-period lasts divSel+1 system clocks. The divSel value is captured when the run starts, and later changes have no effect on that run. A run has exactly 283 rising TCK edges, and TCK rests low between runs.
- R3: TMS and TDI change only while TCK is low, either at a falling TCK edge or when the run starts. They never change at a rising edge or while TCK is high.
- R4: TMS/TDI at the rising edges of TCK cycles 0..9 are: 1/0 five times, 1 cycle at 0/0, 2 cycles at 1/0, then 2 cycles at 0/0. This leaves every TAP in Shift-IR.
- R5: Cycles 10..41 carry TMS=0 and the marker word 0x05253000 on TDI, bit k in cycle 10+k (LSB first).
- R6: Cycles 42..281 carry TDI=1. TMS is 0 in these cycles except in cycle 281, where it is 1. Cycle 282 carries TMS=1 and TDI=0, so the TAP ends in Update-IR.
- R7: done is high for exactly one system clock. It is asserted 566×(divSel+1) system clocks after the clock edge that accepts start.
- R8: TDO is sampled at each rising TCK edge in cycles 10..281. When the last 32 samples, newest in the MSB, equal 0x05253000 at cycle c, the block sets found=1 and irLength=c−41. Only the first match is kept. The largest length it can report is 240.
- R9: TDO values before cycle 10 do not affect the result.
- R10: When no match occurs, found stays 0 and irLength stays 0. Both outputs are cleared when a run is accepted, and they hold their values otherwise.
- R11: A start pulse received during a run is ignored. The run's timing, pattern and result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Requests a run; accepted only while idle |
| divSel | input | DIV_W | TCK half-period minus one, in system clocks |
| tdo | input | 1 | Test data returned by the scan chain |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the scan chain |
| done | output | 1 | One-clock end-of-run pulse |
| found | output | 1 | Marker word was seen in the returned stream |
| irLength | output | LEN_W | Measured total instruction-register length |

## Verification
Every timing follows from the divider. The first rising TCK edge arrives divSel+1 system clocks after the start is accepted, and each later edge of cycle k arrives one half-period after the edge before it. done arrives 566×(divSel+1) clocks after acceptance, and found/irLength are final by that point. The bench counts system clocks from the accepting edge to the first sample, taken on the falling clock, that shows done high, and it requires the count to match exactly. A bench TAP model checks TMS/TDI at each rising TCK edge and produces TDO on the falling edges. The bench reads found and irLength on the clock after done.

// File: rtl/jtag_probe_pkg.sv
package jtag_probe_pkg;

  // Strobes from the control to the datapath, one system clock wide each.
  typedef struct packed {
    logic launch;  // run accepted, load cycle 0 pin values
    logic rise;    // TCK goes high at this edge, sample TDO
    logic fall;    // TCK goes low at this edge, move to next cycle
    logic last;    // current cycle is the final one of the run
  } probe_stb_t;

  // Preamble: reset run, one idle, two select, two capture/shift entry.
  function automatic int runLength(input int resetCyc, input int sigW, input int bypassCyc);
    return resetCyc + 5 + sigW + bypassCyc + 1;
  endfunction

endpackage

// File: rtl/jtag_probe_ctrl.sv
module jtag_probe_ctrl
  import jtag_probe_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int TOTAL_CYC = 283,
  parameter int CYC_W     = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIV_W-1:0] divSel,
  output logic             tck,
  output logic             done,
  output probe_stb_t       stb,
  output logic [CYC_W-1:0] cycIdx
);

  localparam logic [CYC_W-1:0] LAST_IDX = CYC_W'(TOTAL_CYC - 1);

  logic             busy;
  logic [DIV_W-1:0] divHold;
  logic [DIV_W-1:0] halfCnt;
  logic             halfHit;

  assign halfHit = busy && (halfCnt == divHold);

  always_comb begin
    stb.launch = !busy && start;
    stb.rise   = halfHit && !tck;
    stb.fall   = halfHit && tck;
    stb.last   = (cycIdx == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      divHold <= '0;
      halfCnt <= '0;
      cycIdx  <= '0;
      tck     <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          divHold <= divSel;
          halfCnt <= '0;
          cycIdx  <= '0;
          tck     <= 1'b0;
        end
      end else if (halfHit) begin
        halfCnt <= '0;
        tck     <= ~tck;
        if (tck) begin
          if (stb.last) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            cycIdx <= cycIdx + 1'b1;
          end
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/jtag_probe_pattern.sv
module jtag_probe_pattern #(
  parameter int              SIG_W      = 32,
  parameter logic [SIG_W-1:0] SIG_WORD  = 32'h05253000,
  parameter int              RESET_CYC  = 5,
  parameter int              BYPASS_CYC = 240,
  parameter int              CYC_W      = 9
) (
  input  logic [CYC_W-1:0] idx,
  output logic             tmsNext,
  output logic             tdiNext
);

  localparam int IDLE_AT = RESET_CYC;
  localparam int SEL_AT  = RESET_CYC + 1;
  localparam int CAP_AT  = RESET_CYC + 3;
  localparam int SIG_AT  = RESET_CYC + 5;
  localparam int BYP_AT  = SIG_AT + SIG_W;
  localparam int EXIT_AT = BYP_AT + BYPASS_CYC - 1;
  localparam int SIG_IW  = (SIG_W > 1) ? $clog2(SIG_W) : 1;

  logic [SIG_IW-1:0] sigOff;
  assign sigOff = SIG_IW'(idx - CYC_W'(SIG_AT));

  always_comb begin
    tmsNext = 1'b1;
    tdiNext = 1'b0;
    if (idx < CYC_W'(IDLE_AT)) begin
      tmsNext = 1'b1;                 // hold reset
    end else if (idx < CYC_W'(SEL_AT)) begin
      tmsNext = 1'b0;                 // run-test/idle
    end else if (idx < CYC_W'(CAP_AT)) begin
      tmsNext = 1'b1;                 // select-DR, select-IR
    end else if (idx < CYC_W'(SIG_AT)) begin
      tmsNext = 1'b0;                 // capture-IR, shift-IR
    end else if (idx < CYC_W'(BYP_AT)) begin
      tmsNext = 1'b0;
      tdiNext = SIG_WORD[sigOff];     // marker, LSB first
    end else if (idx < CYC_W'(EXIT_AT)) begin
      tmsNext = 1'b0;
      tdiNext = 1'b1;                 // bypass fill
    end else if (idx == CYC_W'(EXIT_AT)) begin
      tmsNext = 1'b1;                 // last fill bit, leave shift
      tdiNext = 1'b1;
    end else begin
      tmsNext = 1'b1;                 // to update-IR
      tdiNext = 1'b0;
    end
  end

endmodule

// File: rtl/jtag_probe_dp.sv
module jtag_probe_dp
  import jtag_probe_pkg::*;
#(
  parameter int               SIG_W      = 32,
  parameter logic [SIG_W-1:0] SIG_WORD   = 32'h05253000,
  parameter int               RESET_CYC  = 5,
  parameter int               BYPASS_CYC = 240,
  parameter int               CYC_W      = 9,
  parameter int               LEN_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  probe_stb_t       stb,
  input  logic [CYC_W-1:0] cycIdx,
  input  logic             tdo,
  output logic             tms,
  output logic             tdi,
  output logic             found,
  output logic [LEN_W-1:0] irLength
);

  localparam int SIG_AT   = RESET_CYC + 5;
  localparam int EXIT_AT  = SIG_AT + SIG_W + BYPASS_CYC - 1;
  localparam int MATCH_AT = SIG_AT + SIG_W - 1;

  logic [CYC_W-1:0] patIdx;
  logic             tmsNext;
  logic             tdiNext;
  logic [SIG_W-1:0] capShift;
  logic [SIG_W-1:0] nextShift;
  logic             inShift;
  logic             hit;

  assign patIdx = stb.launch ? '0 : cycIdx + 1'b1;

  jtag_probe_pattern #(
    .SIG_W(SIG_W), .SIG_WORD(SIG_WORD), .RESET_CYC(RESET_CYC),
    .BYPASS_CYC(BYPASS_CYC), .CYC_W(CYC_W)
  ) u_pattern (
    .idx(patIdx), .tmsNext(tmsNext), .tdiNext(tdiNext)
  );

  assign inShift   = (cycIdx >= CYC_W'(SIG_AT)) && (cycIdx <= CYC_W'(EXIT_AT));
  assign nextShift = {tdo, capShift[SIG_W-1:1]};
  assign hit       = stb.rise && inShift && !found
                   && (cycIdx >= CYC_W'(MATCH_AT)) && (nextShift == SIG_WORD);

  // pin drive: load only while TCK is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tms <= 1'b1;
      tdi <= 1'b0;
    end else if (stb.launch || (stb.fall && !stb.last)) begin
      tms <= tmsNext;
      tdi <= tdiNext;
    end
  end

  // returned-stream capture and marker search
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capShift <= '0;
      found    <= 1'b0;
      irLength <= '0;
    end else if (stb.launch) begin
      capShift <= '0;
      found    <= 1'b0;
      irLength <= '0;
    end else begin
      if (stb.rise && inShift) capShift <= nextShift;
      if (hit) begin
        found    <= 1'b1;
        irLength <= LEN_W'(cycIdx - CYC_W'(MATCH_AT));
      end
    end
  end

endmodule

// File: rtl/jtag_ir_probe.sv
module jtag_ir_probe
  import jtag_probe_pkg::*;
#(
  parameter int               DIV_W      = 8,
  parameter int               SIG_W      = 32,
  parameter logic [SIG_W-1:0] SIG_WORD   = 32'h05253000,
  parameter int               RESET_CYC  = 5,
  parameter int               BYPASS_CYC = 240,
  localparam int              TOTAL_CYC  = runLength(RESET_CYC, SIG_W, BYPASS_CYC),
  localparam int              CYC_W      = $clog2(TOTAL_CYC + 1),
  localparam int              LEN_W      = $clog2(BYPASS_CYC + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIV_W-1:0] divSel,
  input  logic             tdo,
  output logic             tck,
  output logic             tms,
  output logic             tdi,
  output logic             done,
  output logic             found,
  output logic [LEN_W-1:0] irLength
);

  probe_stb_t       stb;
  logic [CYC_W-1:0] cycIdx;

  jtag_probe_ctrl #(
    .DIV_W(DIV_W), .TOTAL_CYC(TOTAL_CYC), .CYC_W(CYC_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .divSel(divSel),
    .tck(tck), .done(done), .stb(stb), .cycIdx(cycIdx)
  );

  jtag_probe_dp #(
    .SIG_W(SIG_W), .SIG_WORD(SIG_WORD), .RESET_CYC(RESET_CYC),
    .BYPASS_CYC(BYPASS_CYC), .CYC_W(CYC_W), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cycIdx(cycIdx), .tdo(tdo),
    .tms(tms), .tdi(tdi), .found(found), .irLength(irLength)
  );

endmodule

// File: rtl/jtag_ir_probe_chk.sv
module jtag_ir_probe_chk #(
  parameter int LEN_W   = 8,
  parameter int LEN_MAX = 240
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             tck,
  input logic             tms,
  input logic             tdi,
  input logic             done,
  input logic             found,
  input logic [LEN_W-1:0] irLength
);

  AST_PINS_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi))); // R3
  AST_PINS_HOLD_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tck) |-> ($stable(tms) && $stable(tdi))); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_DONE_TCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !tck); // R2
  AST_DONE_UPDATE_PINS: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (tms && !tdi)); // R6
  AST_NO_FOUND_ZERO_LEN: assert property (@(posedge clk) disable iff (!rstN)
    !found |-> (irLength == '0)); // R10
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    found |-> (irLength <= LEN_W'(LEN_MAX))); // R8
  AST_FOUND_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    $fell(found) |-> $past(start)); // R10

endmodule

bind jtag_ir_probe jtag_ir_probe_chk #(.LEN_W(LEN_W), .LEN_MAX(BYPASS_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .tck(tck), .tms(tms), .tdi(tdi),
  .done(done), .found(found), .irLength(irLength)
);

// File: tb/jtag_ir_probe_test.sv
module jtag_ir_probe_test;
  timeunit 1ns;
  timeprecision 100ps;

  typedef enum int {
    T_RESET, T_IDLE, T_SELDR, T_CAPDR, T_SHDR, T_EX1DR, T_PAUDR, T_EX2DR, T_UPDDR,
    T_SELIR, T_CAPIR, T_SHIR, T_EX1IR, T_PAUIR, T_EX2IR, T_UPDIR
  } tap_t;

  localparam logic [31:0] MARK = 32'h05253000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] divSel = 8'd0;
  logic       tdo;
  logic       tck, tms, tdi, done, found;
  logic [7:0] irLength;

  int checks = 0;
  int errors = 0;

  // target model state
  int           chainLen = 4;
  bit           garbage = 1'b0;
  bit           stuck = 1'b0;
  logic [255:0] irChain = '0;
  logic         tdoReg = 1'b1;
  tap_t         st = T_RESET;
  int           riseCnt = 0;
  int           patErr = 0;

  jtag_ir_probe uut (
    .clk(clk), .rstN(rstN), .start(start), .divSel(divSel), .tdo(tdo),
    .tck(tck), .tms(tms), .tdi(tdi), .done(done), .found(found), .irLength(irLength)
  );

  always #2.5 clk = ~clk;

  function automatic tap_t tapNext(input tap_t s, input logic m);
    case (s)
      T_RESET: return m ? T_RESET : T_IDLE;
      T_IDLE:  return m ? T_SELDR : T_IDLE;
      T_SELDR: return m ? T_SELIR : T_CAPDR;
      T_CAPDR: return m ? T_EX1DR : T_SHDR;
      T_SHDR:  return m ? T_EX1DR : T_SHDR;
      T_EX1DR: return m ? T_UPDDR : T_PAUDR;
      T_PAUDR: return m ? T_EX2DR : T_PAUDR;
      T_EX2DR: return m ? T_UPDDR : T_SHDR;
      T_UPDDR: return m ? T_SELDR : T_IDLE;
      T_SELIR: return m ? T_RESET : T_CAPIR;
      T_CAPIR: return m ? T_EX1IR : T_SHIR;
      T_SHIR:  return m ? T_EX1IR : T_SHIR;
      T_EX1IR: return m ? T_UPDIR : T_PAUIR;
      T_PAUIR: return m ? T_EX2IR : T_PAUIR;
      T_EX2IR: return m ? T_UPDIR : T_SHIR;
      default: return m ? T_SELDR : T_IDLE;
    endcase
  endfunction

  // expected {tms,tdi} at rising edge k, from R4..R6
  function automatic logic [1:0] expPins(input int k);
    if (k < 5)        return 2'b10;
    else if (k == 5)  return 2'b00;
    else if (k < 8)   return 2'b10;
    else if (k < 10)  return 2'b00;
    else if (k < 42)  return {1'b0, MARK[k-10]};
    else if (k < 281) return 2'b01;
    else if (k == 281) return 2'b11;
    else              return 2'b10;
  endfunction

  always @(posedge tck) begin
    if ({tms, tdi} !== expPins(riseCnt)) patErr = patErr + 1;
    if (st == T_CAPIR) irChain = 256'd1;
    else if (st == T_SHIR && chainLen > 0) begin
      irChain = irChain >> 1;
      irChain[chainLen-1] = tdi;
    end
    st = tapNext(st, tms);
    riseCnt = riseCnt + 1;
  end

  always @(negedge tck) tdoReg = irChain[0];

  assign tdo = stuck ? 1'b0 :
               (st != T_SHIR) ? (garbage ? riseCnt[0] : 1'b1) :
               (chainLen == 0) ? tdi : tdoReg;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs one sequence. midStart: pulse start and change divSel mid-run (R11).
  task automatic runSeq(input int len, input int div, input bit garb, input bit stk,
                        input bit midStart, input bit expFnd, input int expLen);
    int cnt;
    int expN;
    chainLen = len; garbage = garb; stuck = stk;
    riseCnt = 0; patErr = 0; st = T_RESET; irChain = '0;
    expN = 566 * (div + 1);
    @(negedge clk); divSel = 8'(div); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cnt = 0;
    check(found == 1'b0 && irLength == 8'd0, "R10 cleared at start", int'(found), 0);
    while (!done && cnt < 20000) begin
      @(negedge clk);
      cnt++;
      if (midStart && cnt == 100) begin start = 1'b1; divSel = 8'(div + 3); end
      if (midStart && cnt == 101) start = 1'b0;
    end
    check(cnt == expN, midStart ? "R11 done timing" : "R7 done timing", cnt, expN);
    check(riseCnt == 283, "R2 rise count", riseCnt, 283);
    check(patErr == 0, "R4 R5 R6 pin pattern", patErr, 0);
    check(st == T_UPDIR, "R6 final TAP state", int'(st), int'(T_UPDIR));
    @(negedge clk);
    check(done == 1'b0, "R7 done width", int'(done), 0);
    check(tck == 1'b0, "R2 tck idle low", int'(tck), 0);
    check(found == expFnd, garb ? "R9 found" : (expFnd ? "R8 found" : "R10 found"),
          int'(found), int'(expFnd));
    check(irLength == 8'(expLen), garb ? "R9 length" : (expFnd ? "R8 length" : "R10 length"),
          int'(irLength), expLen);
    if (midStart) begin
      repeat (50) @(negedge clk);
      check(tck == 1'b0 && done == 1'b0, "R11 no second run", int'(tck), 0);
    end
  endtask

  localparam int VEC_N = 8;
  localparam int VEC_LEN [VEC_N] = '{4, 4, 0, 5, 12, 240, 241, 7};
  localparam int VEC_DIV [VEC_N] = '{0, 2, 1, 0, 3, 0, 0, 1};
  localparam bit VEC_GRB [VEC_N] = '{0, 1, 0, 1, 0, 0, 0, 1};
  localparam bit VEC_FND [VEC_N] = '{1, 1, 1, 1, 1, 1, 0, 1};
  localparam int VEC_EXP [VEC_N] = '{4, 4, 0, 5, 12, 240, 0, 7};

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tck == 1'b0 && tms == 1'b1 && tdi == 1'b0, "R1 pins", {tck, tms, tdi}, 3'b010);
    check(done == 1'b0 && found == 1'b0 && irLength == 8'd0, "R1 status",
          int'(found), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(tck == 1'b0 && tms == 1'b1, "R1 idle after release", int'(tck), 0);

    for (int i = 0; i < VEC_N; i++)
      runSeq(VEC_LEN[i], VEC_DIV[i], VEC_GRB[i], 1'b0, 1'b0, VEC_FND[i], VEC_EXP[i]);

    // R11: mid-run start and divider change ignored; result kept
    runSeq(9, 1, 1'b0, 1'b0, 1'b1, 1'b1, 9);
    // R10: stuck TDO, no match, previous result cleared
    runSeq(3, 0, 1'b0, 1'b1, 1'b0, 1'b0, 0);
    // R8: short chain after a failed run
    runSeq(1, 0, 1'b1, 1'b0, 1'b0, 1'b1, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule